// File: doc/BRIEF.md
# Phase-Frequency Comparator with Polarity Swap and Lock Flag

This block sits between two divided pulse trains, a reference and a feedback, inside a frequency synthesizer loop. Both arrive as level signals sampled on the system clock. The block watches each one for rising edges. It raises a pump-up or pump-down request according to which edge came first. The request clears as soon as the lagging edge arrives. The requests drive an external charge pump in two forms: a pair of separate request lines, and a 2-bit drive code for a pump that takes a single three-state command.

A polarity input lets the same block serve a loop whose oscillator tunes the other way. With the polarity input high, a leading reference edge asks for up. With it low, the up and down outputs trade places. A lock flag reports when the loop has stayed quiet for several reference periods in a row. Any request drops the flag at once. Both pulse inputs are also brought straight out as monitor outputs.

None of the signals is a data stream, so the block has no valid/ready handshake and applies no back-pressure. Every pin is a plain control or status level.

Top module: `pcmp_top`

## Requirements
- R1: With `pol_i` high, a rising edge on `ref_i` while no request is pending and `fb_i` is low makes `up_o` high after the next clock edge, with `dn_o` low.
- R2: With `pol_i` high, a rising edge on `fb_i` while no request is pending and `ref_i` is not rising makes `dn_o` high after the next clock edge, with `up_o` low.
- R3: Rising edges on both inputs in the same cycle produce no request. A pending request clears on the clock edge that samples the other input's rising edge. `up_o` and `dn_o` are never high together.
- R4: With `pol_i` low, `up_o` and `dn_o` are swapped. The swap applies in the same cycle that `pol_i` changes, even while a request is held.
- R5: `drive_o` is 2'b01 when `up_o` is high, 2'b10 when `dn_o` is high, and 2'b00 (high impedance) when neither is high.
- R6: `lock_o` rises on the clock edge that samples the fourth consecutive reference rising edge counted since the last request ended. A reference edge counts only if it falls in a period with no request.
- R7: `lock_o` is low in every cycle in which `up_o` or `dn_o` is high. A request restarts the count of quiet reference periods from zero.
- R8: `ref_mon_o` equals `ref_i` and `fb_mon_o` equals `fb_i` at all times.
- R9: During and right after reset, `up_o`, `dn_o` and `lock_o` are low and `drive_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_i | input | 1 | Reference pulse train |
| fb_i | input | 1 | Feedback (divided oscillator) pulse train |
| pol_i | input | 1 | Polarity select; high = normal, low = swapped |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |
| drive_o | output | 2 | Combined pump code: 01 up, 10 down, 00 high impedance |
| lock_o | output | 1 | Lock flag |
| ref_mon_o | output | 1 | Copy of ref_i |
| fb_mon_o | output | 1 | Copy of fb_i |

## Verification
Two functions can land in the same cycle. The first case is setting one request and clearing it. The bench provokes this by raising both inputs in one cycle, and again by raising the lagging input while the other request is held. In both cases it expects both request lines low and a drive code of 00 after that edge. The second case is a polarity flip while a request is held. The bench changes `pol_i` mid-request and expects the opposite line and code in that same sample. The lock count and a request can also meet on one reference edge. The bench judges this by the flag falling in the same sample as the request, then taking four fresh quiet periods to return.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
  typedef enum logic [1:0] {
    DRV_HIZ = 2'b00,
    DRV_UP  = 2'b01,
    DRV_DN  = 2'b10
  } drv_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_FB  = 1;
endpackage

// File: rtl/pcmp_edge.sv
module pcmp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/pcmp_core.sv
module pcmp_core (
  input  logic clk,
  input  logic rst_n,
  input  logic lead_rise_i,
  input  logic lag_rise_i,
  output logic lead_q_o,
  output logic lag_q_o
);
  logic lead_q, lag_q;
  logic lead_n, lag_n, clr;

  always_comb begin
    lead_n = lead_q | lead_rise_i;
    lag_n  = lag_q  | lag_rise_i;
    clr    = lead_n & lag_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_q <= 1'b0;
      lag_q  <= 1'b0;
    end else begin
      lead_q <= lead_n & ~clr;
      lag_q  <= lag_n  & ~clr;
    end
  end

  assign lead_q_o = lead_q;
  assign lag_q_o  = lag_q;
endmodule

// File: rtl/pcmp_lock.sv
module pcmp_lock #(
  parameter int unsigned LOCK_PERIODS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic err_i,
  output logic lock_o
);
  localparam int unsigned CW = $clog2(LOCK_PERIODS + 1);
  localparam logic [CW-1:0] LIM = CW'(LOCK_PERIODS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (err_i)                  cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign lock_o = (cnt_q == LIM) & ~err_i;
endmodule

// File: rtl/pcmp_top.sv
module pcmp_top
  import pcmp_pkg::*;
#(
  parameter int unsigned LOCK_PERIODS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_i,
  input  logic       fb_i,
  input  logic       pol_i,
  output logic       up_o,
  output logic       dn_o,
  output logic [1:0] drive_o,
  output logic       lock_o,
  output logic       ref_mon_o,
  output logic       fb_mon_o
);
  logic [NUM_CH-1:0] pulse_in;
  logic [NUM_CH-1:0] rise;
  logic ref_lead_q, fb_lead_q;
  drv_e drv;

  assign pulse_in[CH_REF] = ref_i;
  assign pulse_in[CH_FB]  = fb_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_edge
    pcmp_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (pulse_in[g]),
      .rise_o (rise[g])
    );
  end

  pcmp_core u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .lead_rise_i (rise[CH_REF]),
    .lag_rise_i  (rise[CH_FB]),
    .lead_q_o    (ref_lead_q),
    .lag_q_o     (fb_lead_q)
  );

  pcmp_lock #(.LOCK_PERIODS(LOCK_PERIODS)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (rise[CH_REF]),
    .err_i  (ref_lead_q | fb_lead_q),
    .lock_o (lock_o)
  );

  assign up_o = pol_i ? ref_lead_q : fb_lead_q;
  assign dn_o = pol_i ? fb_lead_q  : ref_lead_q;

  always_comb begin
    if (up_o)      drv = DRV_UP;
    else if (dn_o) drv = DRV_DN;
    else           drv = DRV_HIZ;
  end

  assign drive_o   = drv;
  assign ref_mon_o = ref_i;
  assign fb_mon_o  = fb_i;
endmodule

// File: rtl/pcmp_checker.sv
module pcmp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_i,
  input logic       fb_i,
  input logic       up_o,
  input logic       dn_o,
  input logic [1:0] drive_o,
  input logic       lock_o
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && dn_o)); // R3

  AST_REF_EDGE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_i && !$past(ref_i) && !fb_i && !up_o && !dn_o) |=> (up_o || dn_o)); // R1

  AST_FB_EDGE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_i && !$past(fb_i) && !(ref_i && !$past(ref_i)) && !up_o && !dn_o) |=> (up_o || dn_o)); // R2

  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_o && !dn_o) |-> (drive_o == 2'b00)); // R5

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o || dn_o) |-> !lock_o); // R7
endmodule

bind pcmp_top pcmp_checker u_pcmp_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_i   (ref_i),
  .fb_i    (fb_i),
  .up_o    (up_o),
  .dn_o    (dn_o),
  .drive_o (drive_o),
  .lock_o  (lock_o)
);

// File: tb/pcmp_top_bench.sv
`timescale 1ns/1ps
module pcmp_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_i = 1'b0, fb_i = 1'b0, pol_i = 1'b1;
  logic up_o, dn_o, lock_o, ref_mon_o, fb_mon_o;
  logic [1:0] drive_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pcmp_top u_pcmp_top (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .fb_i(fb_i), .pol_i(pol_i),
    .up_o(up_o), .dn_o(dn_o), .drive_o(drive_o), .lock_o(lock_o),
    .ref_mon_o(ref_mon_o), .fb_mon_o(fb_mon_o)
  );

  // {ref, fb, pol, exp_up, exp_dn, exp_drive[1:0]}
  localparam int NV = 18;
  localparam logic [6:0] VEC [NV] = '{
    7'b1_0_1_1_0_01,  // R1 ref leads
    7'b1_0_1_1_0_01,  // R1 held
    7'b0_1_1_0_0_00,  // R3 lagging edge clears
    7'b0_0_1_0_0_00,
    7'b0_1_1_0_1_10,  // R2 fb leads
    7'b1_1_1_0_0_00,  // R3 clear
    7'b0_0_1_0_0_00,
    7'b1_1_1_0_0_00,  // R3 simultaneous edges
    7'b0_0_0_0_0_00,
    7'b1_0_0_0_1_10,  // R4 swapped: ref leads -> down
    7'b0_1_0_0_0_00,
    7'b0_0_0_0_0_00,
    7'b0_1_0_1_0_01,  // R4 swapped: fb leads -> up
    7'b1_1_0_0_0_00,
    7'b0_0_1_0_0_00,
    7'b1_0_1_1_0_01,  // R1
    7'b1_0_0_0_1_10,  // R4 flip while held
    7'b0_1_0_0_0_00
  };

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic drive_step(input logic r, input logic f);
    ref_i = r; fb_i = f;
    @(negedge clk);
  endtask

  task automatic do_reset();
    ref_i = 0; fb_i = 0; pol_i = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R9 reset state
    chk(up_o == 0 && dn_o == 0 && drive_o == 2'b00 && lock_o == 0, "R9",
        $sformatf("%b%b%b%b", up_o, dn_o, drive_o, lock_o), "00000");

    for (int i = 0; i < NV; i++) begin
      ref_i = VEC[i][6]; fb_i = VEC[i][5]; pol_i = VEC[i][4];
      @(negedge clk);
      chk(up_o == VEC[i][3] && dn_o == VEC[i][2], "R1/R2/R3/R4 req",
          $sformatf("row%0d up=%b dn=%b", i, up_o, dn_o),
          $sformatf("up=%b dn=%b", VEC[i][3], VEC[i][2]));
      chk(drive_o == VEC[i][1:0], "R5 drive",
          $sformatf("row%0d %b", i, drive_o), $sformatf("%b", VEC[i][1:0]));
      chk(ref_mon_o == ref_i && fb_mon_o == fb_i, "R8 monitor",
          $sformatf("%b%b", ref_mon_o, fb_mon_o), $sformatf("%b%b", ref_i, fb_i));
      chk(lock_o == 0, "R7 no lock with errors", $sformatf("%b", lock_o), "0");
    end

    // R6: lock after four quiet aligned periods
    do_reset();
    for (int p = 1; p <= 4; p++) begin
      drive_step(1, 1);
      chk(lock_o == (p == 4), "R6 lock count",
          $sformatf("p%0d %b", p, lock_o), $sformatf("%b", p == 4));
      drive_step(0, 0);
    end
    chk(lock_o == 1, "R6 lock held", $sformatf("%b", lock_o), "1");

    // R7: request drops lock in the same sample, count restarts
    drive_step(1, 0);
    chk(up_o == 1 && lock_o == 0, "R7 drop",
        $sformatf("up=%b lock=%b", up_o, lock_o), "up=1 lock=0");
    drive_step(0, 1);
    chk(up_o == 0 && lock_o == 0, "R7 after clear",
        $sformatf("up=%b lock=%b", up_o, lock_o), "up=0 lock=0");
    drive_step(0, 0);
    for (int p = 1; p <= 4; p++) begin
      drive_step(1, 1);
      chk(lock_o == (p == 4), "R7 relock",
          $sformatf("p%0d %b", p, lock_o), $sformatf("%b", p == 4));
      drive_step(0, 0);
    end

    // R9: reset while requesting
    drive_step(1, 0);
    rst_n = 0;
    @(negedge clk);
    chk(up_o == 0 && dn_o == 0 && lock_o == 0 && drive_o == 2'b00, "R9 in reset",
        $sformatf("%b%b%b%b", up_o, dn_o, drive_o, lock_o), "00000");
    rst_n = 1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule